// File: doc/BRIEF.md
# Banked Memory Mapper with XOR Relocation

This block translates the 16-bit address of an 8-bit CPU into a 19-bit address for a 512 KB external RAM. The CPU space is cut into sixteen 4 KB regions. Each region owns one 8-bit map entry. The entry picks one of eight 64 KB physical pages. It also holds a 3-bit mask that flips CPU lines A13 to A15 on their way to the RAM. Two more bits gate the access: one selects external RAM instead of on-board memory, and one blocks writes.

The CPU loads the entries through a 16-byte port in its own I/O space. The low four address bits of the port pick the entry. Translation is purely combinational, so it adds no wait state. A new entry governs accesses from the next bus cycle on.

Address bit A12 is never altered. A window whose CPU address has A12 fixed can therefore reach only the physical 4 KB blocks that share that value of A12. Software that uses two windows side by side must take this into account.

Top module: `bank_mapper`

## Requirements
- R1: While and after a synchronous active-high reset, every entry is zero: `phys_addr` equals `{3'b000, cpu_addr}`, and `ext_sel`, `wr_inhibit` and `ram_we` are 0.
- R2: `phys_addr[12:0]` always equals `cpu_addr[12:0]`.
- R3: `phys_addr[18:16]` equals the page field, bits [2:0], of the entry selected by the access.
- R4: `phys_addr[15:13]` equals `cpu_addr[15:13]` XOR the mask field, bits [5:3], of the selected entry.
- R5: The selected entry is the one indexed by `cpu_addr[15:12]`, and the entry byte layout is [7] write protect, [6] external enable, [5:3] mask, [2:0] page.
- R6: A CPU write (`bus_wr`=1) to an address in the map port (`MAP_BASE` to `MAP_BASE`+15, default 0xE800) stores `cpu_wdata` into the entry indexed by `cpu_addr[3:0]` at that clock edge. The new value governs translation from the next cycle.
- R7: `ext_sel` equals the external-enable bit of the selected entry, except during a map-port access, when it is 0.
- R8: When the selected entry has write protect set, a write asserts `wr_inhibit` and holds `ram_we` at 0. A read with write protect set leaves `wr_inhibit` at 0.
- R9: `ram_we` is 1 exactly when `bus_wr`=1, `ext_sel`=1 and the region is not write protected.
- R10: A read at the map port changes no entry. Any map-port access drives `ext_sel`, `ram_we` and `wr_inhibit` to 0.
- R11: A window at 0x9000 yields only physical addresses with A12=1, and a window at 0xA000 yields only physical addresses with A12=0, for every mask value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | 1 for a write bus cycle, 0 for a read |
| phys_addr | output | 19 | Translated RAM address |
| ext_sel | output | 1 | Selects external RAM for this access |
| wr_inhibit | output | 1 | Write blocked by write protect |
| ram_we | output | 1 | RAM write strobe |

## Verification
The four outputs are combinational functions of the current address, the write flag and the stored entry. They are due in the same cycle as the address, so the bench drives inputs on the falling edge and compares a few nanoseconds later, before the next rising edge. An entry write lands on the rising edge that ends the port cycle. Its effect is therefore checked only from the following falling edge, and the region it overwrites is read once before the write to show that the old value held until then.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
    localparam int CPU_AW      = 16;
    localparam int PHYS_AW     = 19;
    localparam int PAGE_BITS   = PHYS_AW - CPU_AW;
    localparam int MASK_BITS   = 3;
    localparam int REGION_BITS = 4;
    localparam int NUM_REGIONS = 1 << REGION_BITS;
    localparam int PASS_BITS   = CPU_AW - MASK_BITS;
    localparam int ENTRY_BITS  = PAGE_BITS + MASK_BITS + 2;

    typedef struct packed {
        logic                 wprot;
        logic                 ext_en;
        logic [MASK_BITS-1:0] xmask;
        logic [PAGE_BITS-1:0] page;
    } map_entry_t;

    typedef struct packed {
        logic [PHYS_AW-1:0] addr;
        logic               ext_sel;
        logic               wr_inhibit;
        logic               ram_we;
    } xlate_out_t;

    function automatic logic [PHYS_AW-1:0] relocate(
        input logic [CPU_AW-1:0] a,
        input map_entry_t        e
    );
        return {e.page, a[CPU_AW-1:PASS_BITS] ^ e.xmask, a[PASS_BITS-1:0]};
    endfunction
endpackage

// File: rtl/map_port_decode.sv
module map_port_decode
    import bank_map_pkg::*;
#(
    parameter logic [CPU_AW-1:0] MAP_BASE = 16'hE800
) (
    input  logic [CPU_AW-1:0]      addr,
    input  logic                   bus_wr,
    output logic                   port_hit,
    output logic                   port_wr,
    output logic [REGION_BITS-1:0] port_idx
);
    always_comb begin
        port_hit = (addr[CPU_AW-1:REGION_BITS] == MAP_BASE[CPU_AW-1:REGION_BITS]);
        port_wr  = port_hit & bus_wr;
        port_idx = addr[REGION_BITS-1:0];
    end
endmodule

// File: rtl/map_table.sv
module map_table
    import bank_map_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [REGION_BITS-1:0] wr_idx,
    input  map_entry_t             wr_data,
    input  logic [REGION_BITS-1:0] rd_idx,
    output map_entry_t             rd_entry
);
    map_entry_t regs [NUM_REGIONS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGIONS; i++) regs[i] <= '0;
        end else if (wr_en) begin
            regs[wr_idx] <= wr_data;
        end
    end

    assign rd_entry = regs[rd_idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs[$past(wr_idx)] == $past(wr_data)); // R6

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> regs[$past(rd_idx)] == $past(rd_entry)); // R10
endmodule

// File: rtl/map_translate.sv
module map_translate
    import bank_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CPU_AW-1:0] addr,
    input  logic              bus_wr,
    input  logic              port_hit,
    input  map_entry_t        entry,
    output xlate_out_t        xo
);
    always_comb begin
        xo.addr       = relocate(addr, entry);
        xo.ext_sel    = entry.ext_en & ~port_hit;
        xo.wr_inhibit = bus_wr & entry.wprot & ~port_hit;
        xo.ram_we     = bus_wr & xo.ext_sel & ~entry.wprot;
    end

    AST_WP_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        xo.wr_inhibit |-> !xo.ram_we); // R8

    AST_STROBE_NEEDS_EXT: assert property (@(posedge clk) disable iff (rst)
        xo.ram_we |-> (xo.ext_sel && bus_wr)); // R9

    AST_PORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        port_hit |-> (!xo.ext_sel && !xo.ram_we && !xo.wr_inhibit)); // R10
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_map_pkg::*;
#(
    parameter logic [15:0] MAP_BASE = 16'hE800
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        bus_wr,
    output logic [18:0] phys_addr,
    output logic        ext_sel,
    output logic        wr_inhibit,
    output logic        ram_we
);
    logic                   port_hit;
    logic                   port_wr;
    logic [REGION_BITS-1:0] port_idx;
    map_entry_t             cur_entry;
    xlate_out_t             xo;

    map_port_decode #(.MAP_BASE(MAP_BASE)) u_dec (
        .addr     (cpu_addr),
        .bus_wr   (bus_wr),
        .port_hit (port_hit),
        .port_wr  (port_wr),
        .port_idx (port_idx)
    );

    map_table u_tab (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (port_wr),
        .wr_idx   (port_idx),
        .wr_data  (map_entry_t'(cpu_wdata)),
        .rd_idx   (cpu_addr[CPU_AW-1:CPU_AW-REGION_BITS]),
        .rd_entry (cur_entry)
    );

    map_translate u_xl (
        .clk      (clk),
        .rst      (rst),
        .addr     (cpu_addr),
        .bus_wr   (bus_wr),
        .port_hit (port_hit),
        .entry    (cur_entry),
        .xo       (xo)
    );

    assign phys_addr  = xo.addr;
    assign ext_sel    = xo.ext_sel;
    assign wr_inhibit = xo.wr_inhibit;
    assign ram_we     = xo.ram_we;

    AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
        phys_addr[PASS_BITS-1:0] == cpu_addr[PASS_BITS-1:0]); // R2
endmodule

// File: tb/bank_mapper_test.sv
`timescale 1ns/1ps
module bank_mapper_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        bus_wr = 1'b0;
    logic [18:0] phys_addr;
    logic        ext_sel, wr_inhibit, ram_we;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bank_mapper uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .bus_wr(bus_wr), .phys_addr(phys_addr), .ext_sel(ext_sel),
        .wr_inhibit(wr_inhibit), .ram_we(ram_we)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected address from R3/R4/R2 and the R5 byte layout
    function automatic logic [18:0] exp_phys(input logic [15:0] a, input logic [7:0] e);
        return {e[2:0], a[15:13] ^ e[5:3], a[12:0]};
    endfunction

    task automatic drive(input logic [15:0] a, input logic w, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; bus_wr = w; cpu_wdata = d;
        #2;
    endtask

    task automatic put_entry(input logic [3:0] idx, input logic [7:0] val);
        drive(16'hE800 | {12'h0, idx}, 1'b1, val);
        chk("R10 port write no strobe", {ext_sel, ram_we, wr_inhibit}, 3'b000);
    endtask

    task automatic t_reset();
        for (int r = 0; r < 16; r++) begin
            if (r == 14) continue;
            drive({r[3:0], 12'h5A5}, 1'b1, 8'h00);
            chk("R1 identity", phys_addr, {3'b000, r[3:0], 12'h5A5});
            chk("R1 outputs idle", {ext_sel, wr_inhibit, ram_we}, 3'b000);
        end
    endtask

    task automatic t_page_mask();
        put_entry(4'h2, 8'h45);  // ext, mask 000, page 5
        drive(16'h2345, 1'b0, 8'h00);
        chk("R3 page", phys_addr, exp_phys(16'h2345, 8'h45));
        chk("R7 ext on", ext_sel, 1'b1);
        for (int m = 0; m < 8; m++) begin
            logic [7:0] e;
            e = {2'b01, m[2:0], 3'b011};
            put_entry(4'h7, e);
            drive(16'h7FFF, 1'b0, 8'h00);
            chk("R4 xor mask", phys_addr, exp_phys(16'h7FFF, e));
            chk("R2 low bits", phys_addr[12:0], 13'h1FFF);
        end
        drive(16'h6FFF, 1'b0, 8'h00);
        chk("R5 neighbour region untouched", phys_addr, {3'b000, 16'h6FFF});
        chk("R7 ext off", ext_sel, 1'b0);
    endtask

    task automatic t_port_timing();
        drive(16'h3123, 1'b0, 8'h00);
        chk("R6 old value before write", phys_addr, {3'b000, 16'h3123});
        put_entry(4'h3, 8'h4A);
        drive(16'h3123, 1'b0, 8'h00);
        chk("R6 new value next cycle", phys_addr, 19'h21123);
        drive(16'hE803, 1'b0, 8'hFF);   // port read must not write
        drive(16'h3123, 1'b0, 8'h00);
        chk("R10 port read keeps entry", phys_addr, 19'h21123);
    endtask

    task automatic t_protect();
        put_entry(4'h4, 8'hC1);         // wp, ext, page 1
        drive(16'h4010, 1'b1, 8'h55);
        chk("R8 write blocked", {wr_inhibit, ram_we}, 2'b10);
        drive(16'h4010, 1'b0, 8'h00);
        chk("R8 read unaffected", {wr_inhibit, ram_we, ext_sel}, 3'b001);
        put_entry(4'h5, 8'h41);         // ext, no wp
        drive(16'h5010, 1'b1, 8'h55);
        chk("R9 strobe on", {wr_inhibit, ram_we}, 2'b01);
        drive(16'h5010, 1'b0, 8'h00);
        chk("R9 no strobe on read", ram_we, 1'b0);
        put_entry(4'h6, 8'h01);         // on-board, no wp
        drive(16'h6010, 1'b1, 8'h00);
        chk("R9 no strobe without ext", ram_we, 1'b0);
    endtask

    task automatic t_port_region();
        put_entry(4'hE, 8'h40);
        drive(16'hE000, 1'b1, 8'h00);
        chk("R7 region E external", {ext_sel, ram_we}, 2'b11);
        drive(16'hE80F, 1'b0, 8'h00);
        chk("R10 port read quiet", {ext_sel, ram_we, wr_inhibit}, 3'b000);
    endtask

    task automatic t_window();
        for (int m = 0; m < 8; m++) begin
            put_entry(4'h9, {2'b01, m[2:0], 3'b001});
            put_entry(4'hA, {2'b01, m[2:0], 3'b001});
            drive(16'h9ABC, 1'b0, 8'h00);
            chk("R11 window 9 A12=1", phys_addr[12], 1'b1);
            drive(16'hAABC, 1'b0, 8'h00);
            chk("R11 window A A12=0", phys_addr[12], 1'b0);
        end
        drive(16'h9ABC, 1'b0, 8'h00);
        chk("R11 window 9 full", phys_addr, exp_phys(16'h9ABC, 8'h79));
    endtask

    task automatic t_rereset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        drive(16'h3123, 1'b0, 8'h00);
        chk("R1 entries cleared", {ext_sel, phys_addr}, {1'b0, 3'b000, 16'h3123});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_page_mask();
        t_port_timing();
        t_protect();
        t_port_region();
        t_window();
        t_rereset();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule